// File: doc/BRIEF.md
# Bus and Local Wake-Up Detector

This block watches two wake sources on behalf of a transceiver's mode controller. The first is the digitised level of the single-wire bus receiver, dominant or recessive. The second is a local wake pin. A qualified event on either source produces a one-cycle pulse. The block also keeps a sticky flag that records that the most recent wake came from the bus. The mode controller uses this flag to hold the receive-data indication low while the part sits in stand-by. Analog thresholds are outside the block. It sees only clean digital levels, sampled on every clock.

A bus wake needs a full gesture: the bus falls to dominant, stays dominant for longer than a parameterised hold time, and then returns to recessive. A local wake is a level change of the wake pin in either direction. It is accepted only after the new level has been held for a parameterised debounce time, and it raises a pulse only while the mode is sleep. All pins are plain control and status signals. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Mode encoding on `mode_i`: 0 = sleep, 1 = stand-by, 2 = normal, 3 = normal with reduced slope. Bit 1 set means a normal mode.

Top module: `wake_detect`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `bus_wake_o`, `local_wake_o` and `bus_src_o` are 0. The bus level is treated as dominant at reset, so a bus that is already dominant is not taken as a falling edge.
- R2: In sleep or stand-by, the following sequence produces exactly one `bus_wake_o` pulse, one cycle wide, in the cycle after the first recessive sample:
  - a recessive-to-dominant change of `bus_dom_i`,
  - more than `HOLD_CYC` consecutive dominant samples,
  - a recessive sample.
- R3: A dominant run of `HOLD_CYC` samples or fewer abandons the sequence and produces no bus pulse.
- R4: In either normal mode the bus detector is idle and produces no pulse. A sequence in progress when a normal mode is entered is dropped. A new falling edge is then needed.
- R5: In sleep, a change of `wake_pin_i` in either direction is accepted once the pin has differed from the last accepted level for `DEB_CYC` consecutive samples. `local_wake_o` pulses for one cycle in the cycle after that sample. The accepted level resets to 0.
- R6: A wake-pin excursion shorter than `DEB_CYC` samples produces no local pulse.
- R7: Outside sleep, accepted wake-pin changes produce no pulse. The accepted level still follows the pin, so returning to sleep with the pin unchanged gives no pulse.
- R8: `bus_src_o` rises in the cycle after a bus pulse, unless the mode is normal or `clr_i` is high. It then holds. Local wakes never change it.
- R9: `bus_src_o` is 0 in the cycle after any cycle in which the mode is normal or `clr_i` is high. The clear takes priority over a set.
- R10: If a bus wake and a local wake qualify on the same sample, both pulses appear in the same cycle and `bus_src_o` is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous power-off reset |
| mode_i | input | 2 | Current mode: 0 sleep, 1 stand-by, 2 normal, 3 normal reduced slope |
| bus_dom_i | input | 1 | Digitised bus level, 1 = dominant |
| wake_pin_i | input | 1 | Local wake pin level |
| clr_i | input | 1 | Clears the bus-source flag |
| bus_wake_o | output | 1 | One-cycle pulse on a qualified bus wake |
| local_wake_o | output | 1 | One-cycle pulse on a qualified local wake in sleep |
| bus_src_o | output | 1 | Sticky flag: the last wake came from the bus |

## Verification
The bus input is driven with dominant runs of exactly `HOLD_CYC` and `HOLD_CYC`+1 samples, which locates the hold boundary. It is also driven with a long run in normal mode and with a run split by a visit to normal mode. Together these separate a correct edge-gated sequence from one that only measures dominant time.

The wake pin is driven with these patterns:
- held changes in both directions,
- a glitch one sample short of the debounce time,
- changes made outside sleep and then a return to sleep.

These distinguish edge detection from level detection and show that the accepted level is tracked in every mode.

A final pattern lines up a bus release and a local acceptance on the same sample, to show that both pulses appear and that the flag gives the bus priority.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    MD_SLEEP   = 2'd0,
    MD_STBY    = 2'd1,
    MD_NORM    = 2'd2,
    MD_NORM_LO = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    BW_IDLE  = 2'd0,
    BW_HOLD  = 2'd1,
    BW_ARMED = 2'd2
  } bw_state_e;

  function automatic logic mode_is_normal(input mode_e m);
    return m[1];
  endfunction
endpackage

// File: rtl/bus_wake_seq.sv
module bus_wake_seq #(
  parameter int HOLD_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic dom_i,
  output logic hit_o
);
  import wake_pkg::*;
  localparam int CW = $clog2(HOLD_CYC + 1) + 1;

  bw_state_e       state;
  logic [CW-1:0]   run_cnt;
  logic            dom_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= BW_IDLE;
      run_cnt <= '0;
      dom_q   <= 1'b1;
      hit_o   <= 1'b0;
    end else begin
      dom_q <= dom_i;
      hit_o <= 1'b0;
      if (!active_i) begin
        state   <= BW_IDLE;
        run_cnt <= '0;
      end else begin
        unique case (state)
          BW_IDLE: begin
            if (dom_i && !dom_q) begin
              state   <= BW_HOLD;
              run_cnt <= CW'(1);
            end
          end
          BW_HOLD: begin
            if (!dom_i) begin
              state <= BW_IDLE;
            end else if (run_cnt == CW'(HOLD_CYC)) begin
              state <= BW_ARMED;
            end else begin
              run_cnt <= run_cnt + CW'(1);
            end
          end
          BW_ARMED: begin
            if (!dom_i) begin
              hit_o <= 1'b1;
              state <= BW_IDLE;
            end
          end
          default: state <= BW_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/local_wake_filt.sv
module local_wake_filt #(
  parameter int DEB_CYC = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  input  logic pin_i,
  output logic hit_o
);
  localparam int CW = $clog2(DEB_CYC + 1) + 1;

  logic          level_q;
  logic [CW-1:0] diff_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      diff_cnt <= '0;
      hit_o    <= 1'b0;
    end else begin
      hit_o <= 1'b0;
      if (pin_i != level_q) begin
        if (diff_cnt == CW'(DEB_CYC - 1)) begin
          level_q  <= pin_i;
          diff_cnt <= '0;
          hit_o    <= sleep_i;
        end else begin
          diff_cnt <= diff_cnt + CW'(1);
        end
      end else begin
        diff_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/wake_src_flag.sv
module wake_src_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_hit_i,
  input  logic normal_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
    end else if (clr_i || normal_i) begin
      flag_o <= 1'b0;
    end else if (bus_hit_i) begin
      flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int HOLD_CYC = 3000,
  parameter int DEB_CYC  = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       bus_dom_i,
  input  logic       wake_pin_i,
  input  logic       clr_i,
  output logic       bus_wake_o,
  output logic       local_wake_o,
  output logic       bus_src_o
);
  import wake_pkg::*;

  mode_e mode;
  logic  in_normal;
  logic  in_sleep;

  assign mode      = mode_e'(mode_i);
  assign in_normal = mode_is_normal(mode);
  assign in_sleep  = (mode == MD_SLEEP);

  bus_wake_seq #(.HOLD_CYC(HOLD_CYC)) u_bus (
    .clk      (clk),
    .rst_n    (rst_n),
    .active_i (!in_normal),
    .dom_i    (bus_dom_i),
    .hit_o    (bus_wake_o)
  );

  local_wake_filt #(.DEB_CYC(DEB_CYC)) u_loc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep_i (in_sleep),
    .pin_i   (wake_pin_i),
    .hit_o   (local_wake_o)
  );

  wake_src_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_hit_i (bus_wake_o),
    .normal_i  (in_normal),
    .clr_i     (clr_i),
    .flag_o    (bus_src_o)
  );
endmodule

// File: rtl/wake_detect_chk.sv
module wake_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic       bus_dom_i,
  input logic       clr_i,
  input logic       bus_wake_o,
  input logic       local_wake_o,
  input logic       bus_src_o
);
  assert_bus_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wake_o |=> !bus_wake_o);

  assert_bus_after_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wake_o |-> !$past(bus_dom_i));

  assert_no_bus_in_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wake_o |-> !$past(mode_i[1]));

  assert_local_in_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    local_wake_o |-> ($past(mode_i) == 2'd0));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wake_o && !clr_i && !mode_i[1]) |=> bus_src_o);

  assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_src_o) |-> $past(bus_wake_o));

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i || mode_i[1]) |=> !bus_src_o);
endmodule

bind wake_detect wake_detect_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .bus_dom_i    (bus_dom_i),
  .clr_i        (clr_i),
  .bus_wake_o   (bus_wake_o),
  .local_wake_o (local_wake_o),
  .bus_src_o    (bus_src_o)
);

// File: tb/wake_detect_tb.sv
module wake_detect_tb;
  localparam int HOLD = 20;
  localparam int DEB  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       dom = 1'b0, pin = 1'b0, clr = 1'b0;
  logic       bus_wake, loc_wake, src;

  int checks = 0, errors = 0;
  int nbus = 0, nloc = 0, nboth = 0;

  always #5 clk = ~clk;

  wake_detect #(.HOLD_CYC(HOLD), .DEB_CYC(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .bus_dom_i(dom),
    .wake_pin_i(pin), .clr_i(clr),
    .bus_wake_o(bus_wake), .local_wake_o(loc_wake), .bus_src_o(src)
  );

  // behavioural reference
  int run, dcnt;
  bit mprev, macc, e_bus, e_loc, e_flag;
  always @(posedge clk) begin
    if (!rst_n) begin
      run = -1; dcnt = 0; mprev = 1; macc = 0;
      e_bus = 0; e_loc = 0; e_flag = 0;
    end else begin
      if (clr || mode >= 2) e_flag = 0;
      else if (e_bus) e_flag = 1;
      e_bus = 0;
      if (mode < 2) begin
        if (dom) begin
          if (!mprev) run = 1;
          else if (run > 0) run++;
        end else begin
          if (run > HOLD) e_bus = 1;
          run = -1;
        end
      end else run = -1;
      mprev = dom;
      e_loc = 0;
      if (pin != macc) begin
        dcnt++;
        if (dcnt == DEB) begin
          macc = pin; dcnt = 0; e_loc = (mode == 0);
        end
      end else dcnt = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R2 bus pulse vs model", bus_wake, e_bus);
    chk("R5 local pulse vs model", loc_wake, e_loc);
    chk("R8 flag vs model", src, e_flag);
    if (rst_n) begin
      if (bus_wake) nbus++;
      if (loc_wake) nloc++;
      if (bus_wake && loc_wake) nboth++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 reset bus", bus_wake, 0);
    chk("R1 reset local", loc_wake, 0);
    chk("R1 reset flag", src, 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 first cycle flag", src, 0);

    // R2 sleep bus wake
    mode = 2'd0; step(2); nbus = 0;
    dom = 1; step(30); dom = 0; step(3);
    chk("R2 sleep bus wake count", nbus, 1);
    chk("R8 flag after bus wake", src, 1);

    // R3 / R2 boundary in stand-by
    mode = 2'd1; step(2); nbus = 0;
    dom = 1; step(HOLD); dom = 0; step(3);
    chk("R3 hold equal to limit", nbus, 0);
    dom = 1; step(HOLD + 1); dom = 0; step(3);
    chk("R2 hold one past limit", nbus, 1);

    // R4 / R9 normal mode
    mode = 2'd2; step(2);
    chk("R9 flag cleared in normal", src, 0);
    nbus = 0;
    dom = 1; step(30); dom = 0; step(3);
    chk("R4 no bus wake in normal", nbus, 0);
    mode = 2'd1; step(2);
    dom = 1; step(10); mode = 2'd3; step(15); mode = 2'd1; step(10);
    dom = 0; step(3);
    chk("R4 sequence dropped by normal", nbus, 0);

    // R5 / R6 local wake in sleep
    mode = 2'd0; step(2); nloc = 0;
    pin = 1; step(12);
    chk("R5 rising wake pin", nloc, 1);
    pin = 0; step(12);
    chk("R5 falling wake pin", nloc, 2);
    pin = 1; step(DEB - 1); pin = 0; step(10);
    chk("R6 short glitch", nloc, 2);
    chk("R8 local wake leaves flag", src, 0);

    // R7 outside sleep
    mode = 2'd1; pin = 1; step(12); pin = 0; step(12);
    chk("R7 standby edges", nloc, 2);
    mode = 2'd2; pin = 1; step(12);
    chk("R7 normal edge", nloc, 2);
    mode = 2'd0; step(12);
    chk("R7 level tracked, no pulse on return", nloc, 2);

    // R8 / R9 flag hold and clear
    dom = 1; step(25); dom = 0; step(3);
    chk("R8 flag set in sleep", src, 1);
    pin = 0; step(12);
    chk("R8 flag kept after local wake", src, 1);
    clr = 1; step(1); clr = 0; step(1);
    chk("R9 clear input", src, 0);

    // R10 simultaneous qualification
    nboth = 0;
    dom = 1; step(18); pin = 1; step(7); dom = 0; step(3);
    chk("R10 both pulses same cycle", nboth, 1);
    chk("R10 flag set by bus", src, 1);

    step(5);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule